// File: doc/BRIEF.md
# Bit-Serial Multiplier Loop Sequencer

This block drives the control strobes of a shift-and-add multiplier that handles one operand bit per cycle. After a start request it runs two nested loops, each `N` passes long. On every inner pass it tells the datapath to shift the multiplicand, select the adder result and shift the high half of the product. When an inner loop ends, it spends one cycle shifting the multiplier and both product halves. When the last outer pass is over it pulses a completion strobe and waits for the next request.

Loop position comes from a small four-state machine. Two parameterised binary counters hold the pass counts. Each counter has a count enable, a synchronous clear and a flag that is high at its last value. The state machine reads these flags to decide when to leave each loop, so it never has to list the loop indices as states of its own.

Top module: `serial_mult_sequencer`

## Requirements
- R1: During reset, and in the first cycle after reset, all six strobes are 0. A reset applied mid-operation returns the block to idle.
- R2: While idle with `start` low, all strobes stay 0. If `start` is high at a clock edge while idle, the first inner cycle is the cycle that follows that edge.
- R3: In an inner cycle exactly `shift_mcand`, `sel_sum` and `shift_hi` are 1 and the other three strobes are 0.
- R4: After every run of `N` consecutive inner cycles there is exactly one step cycle. In it exactly `shift_mplier`, `shift_hi` and `shift_lo` are 1, and then the inner count starts again from zero.
- R5: The outer loop runs `N` times, so one operation gives exactly `N*(N+1)` strobe cycles. `done` is high for exactly the one cycle after the last step cycle, and the block is idle in the cycle after that.
- R6: `start` has no effect while an operation or its `done` cycle is in progress. The strobe sequence and its length are unchanged when `start` is held high throughout.
- R7: In any cycle at most one of the three strobe groups (inner, step, done) is active.
- R8: `N` must be at least 2, and this is checked at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| shift_mcand | output | 1 | Shift multiplicand (inner cycle) |
| sel_sum | output | 1 | Load adder sum into high product (inner cycle) |
| shift_hi | output | 1 | Shift high product half (inner and step cycles) |
| shift_mplier | output | 1 | Shift multiplier (step cycle) |
| shift_lo | output | 1 | Shift low product half (step cycle) |
| done | output | 1 | One-cycle completion pulse |

## Verification
All strobes are decoded from the state register, so each one appears in the cycle right after the edge that causes it. The first inner cycle follows the edge that samples `start`. Cycle `c` after that edge is an inner cycle when `c mod (N+1) < N` and a step cycle otherwise. `done` follows at `c = N*(N+1)`, and idle comes one cycle after that. The bench drives inputs and samples all six strobes on the falling edge. It computes the expected vector for every cycle index from these formulas and compares against it. This is repeated with `start` pulsed, with `start` held high across the whole run and its `done` cycle, with back-to-back runs, and after a reset in the middle of a run.

// File: rtl/serial_mult_seq_pkg.sv
package serial_mult_seq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_INNER = 2'd1,
      ST_STEP  = 2'd2,
      ST_DONE  = 2'd3
   } seq_state_t;

   typedef struct packed {
      logic shift_mcand;
      logic sel_sum;
      logic shift_hi;
      logic shift_mplier;
      logic shift_lo;
      logic done;
   } strobe_t;
endpackage

// File: rtl/pass_counter.sv
module pass_counter #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic ce,
   input  logic clr,
   output logic tc
);
   localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
   localparam bit POW2 = (LIMIT == (1 << CW));

   logic [CW-1:0] q;

   initial begin
      if (LIMIT < 2) $error("pass_counter: LIMIT must be at least 2 (R8)");
   end

   always_ff @(posedge clk) begin
      if (rst || clr) q <= '0;
      else if (ce)    q <= q + 1'b1;
   end

   generate
      if (POW2) begin : g_tc_and
         assign tc = &q;
      end else begin : g_tc_cmp
         assign tc = (q == LAST);
      end
   endgenerate

   assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
      (ce && !clr && !tc) |=> (q == $past(q) + 1'b1));
   assert_count_clear_R4: assert property (@(posedge clk) disable iff (rst)
      clr |=> (q == '0));
   assert_count_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (!ce && !clr) |=> $stable(q));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
   import serial_mult_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       start,
   input  logic       inner_last,
   input  logic       outer_last,
   output seq_state_t state,
   output logic       inner_ce,
   output logic       inner_clr,
   output logic       outer_ce,
   output logic       outer_clr
);
   seq_state_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:  if (start) nxt = ST_INNER;
         ST_INNER: if (inner_last) nxt = ST_STEP;
         ST_STEP:  nxt = outer_last ? ST_DONE : ST_INNER;
         ST_DONE:  nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= ST_IDLE;
      else     state <= nxt;
   end

   assign inner_ce  = (state == ST_INNER);
   assign inner_clr = (state == ST_STEP) || (state == ST_IDLE);
   assign outer_ce  = (state == ST_STEP);
   assign outer_clr = (state == ST_IDLE) || (state == ST_DONE);

   assert_step_after_inner_R4: assert property (@(posedge clk) disable iff (rst)
      (state == ST_STEP) |-> ($past(state) == ST_INNER));
   assert_done_after_step_R5: assert property (@(posedge clk) disable iff (rst)
      (state == ST_DONE) |-> ($past(state) == ST_STEP));
   assert_busy_ignores_start_R6: assert property (@(posedge clk) disable iff (rst)
      (state == ST_DONE) |=> (state == ST_IDLE));
endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
   import serial_mult_seq_pkg::*;
(
   input  seq_state_t state,
   output strobe_t    strb
);
   always_comb begin
      strb = '0;
      unique case (state)
         ST_INNER: begin
            strb.shift_mcand = 1'b1;
            strb.sel_sum     = 1'b1;
            strb.shift_hi    = 1'b1;
         end
         ST_STEP: begin
            strb.shift_mplier = 1'b1;
            strb.shift_hi     = 1'b1;
            strb.shift_lo     = 1'b1;
         end
         ST_DONE: strb.done = 1'b1;
         default: strb = '0;
      endcase
   end
endmodule

// File: rtl/serial_mult_sequencer.sv
module serial_mult_sequencer
   import serial_mult_seq_pkg::*;
#(
   parameter int N = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic shift_mcand,
   output logic sel_sum,
   output logic shift_hi,
   output logic shift_mplier,
   output logic shift_lo,
   output logic done
);
   seq_state_t state;
   strobe_t    strb;
   logic inner_last, outer_last;
   logic inner_ce, inner_clr, outer_ce, outer_clr;

   initial begin
      if (N < 2) $error("serial_mult_sequencer: N must be at least 2 (R8)");
   end

   seq_fsm u_fsm (
      .clk(clk), .rst(rst), .start(start),
      .inner_last(inner_last), .outer_last(outer_last),
      .state(state),
      .inner_ce(inner_ce), .inner_clr(inner_clr),
      .outer_ce(outer_ce), .outer_clr(outer_clr)
   );

   pass_counter #(.LIMIT(N)) u_inner (
      .clk(clk), .rst(rst), .ce(inner_ce), .clr(inner_clr), .tc(inner_last)
   );

   pass_counter #(.LIMIT(N)) u_outer (
      .clk(clk), .rst(rst), .ce(outer_ce), .clr(outer_clr), .tc(outer_last)
   );

   strobe_decode u_dec (.state(state), .strb(strb));

   assign shift_mcand  = strb.shift_mcand;
   assign sel_sum      = strb.sel_sum;
   assign shift_hi     = strb.shift_hi;
   assign shift_mplier = strb.shift_mplier;
   assign shift_lo     = strb.shift_lo;
   assign done         = strb.done;

   assert_group_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
      $onehot0({shift_mcand, shift_mplier, done}));
   assert_inner_pattern_R3: assert property (@(posedge clk) disable iff (rst)
      shift_mcand |-> (sel_sum && shift_hi && !shift_lo));
   assert_step_then_inner_R4: assert property (@(posedge clk) disable iff (rst)
      (shift_mplier && !outer_last) |=> shift_mcand);
   assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   assert_start_no_restart_R6: assert property (@(posedge clk) disable iff (rst)
      (shift_mcand && start) |=> (shift_mcand || shift_mplier));
endmodule

// File: tb/serial_mult_sequencer_bench.sv
module serial_mult_sequencer_bench;
   localparam int N     = 4;
   localparam int TOTAL = N * (N + 1);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic shift_mcand, sel_sum, shift_hi, shift_mplier, shift_lo, done;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   serial_mult_sequencer #(.N(N)) u_serial_mult_sequencer (
      .clk(clk), .rst(rst), .start(start),
      .shift_mcand(shift_mcand), .sel_sum(sel_sum), .shift_hi(shift_hi),
      .shift_mplier(shift_mplier), .shift_lo(shift_lo), .done(done)
   );

   localparam logic [5:0] V_IDLE  = 6'b000000;
   localparam logic [5:0] V_INNER = 6'b111000;
   localparam logic [5:0] V_STEP  = 6'b001110;
   localparam logic [5:0] V_DONE  = 6'b000001;

   function automatic logic [5:0] expect_at(int c);
      if (c == TOTAL)           return V_DONE;
      if (c > TOTAL)            return V_IDLE;
      if ((c % (N + 1)) < N)    return V_INNER;
      return V_STEP;
   endfunction

   task automatic check(input logic [5:0] exp, input string tag);
      logic [5:0] got;
      got = {shift_mcand, sel_sum, shift_hi, shift_mplier, shift_lo, done};
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   function automatic string tag_for(int c);
      if (c == TOTAL)          return "R5 done pulse";
      if ((c % (N + 1)) < N)   return "R3 inner cycle";
      return "R4 step cycle";
   endfunction

   task automatic run_op(input bit hold);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      if (!hold) start = 1'b0;
      for (int c = 0; c <= TOTAL; c++) begin
         check(expect_at(c), hold ? {tag_for(c), " R6 start held"} : tag_for(c));
         @(negedge clk);
      end
      check(V_IDLE, hold ? "R6 no restart after done" : "R5 idle after done");
      start = 1'b0;
   endtask

   initial begin
      #(4 * 100000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(V_IDLE, "R1 in reset");
      rst = 1'b0;
      @(negedge clk);
      check(V_IDLE, "R1 after reset");
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(V_IDLE, "R2 idle without start");
      end

      run_op(1'b0);
      @(negedge clk);
      check(V_IDLE, "R2 idle between runs");

      run_op(1'b1);
      @(negedge clk);
      check(V_IDLE, "R6 idle after held start");

      run_op(1'b0);
      run_op(1'b0);

      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < N + 3; c++) begin
         check(expect_at(c), "R4 partial run");
         @(negedge clk);
      end
      rst = 1'b1;
      @(negedge clk);
      check(V_IDLE, "R1 mid-run reset");
      rst = 1'b0;
      @(negedge clk);
      check(V_IDLE, "R1 idle after mid-run reset");
      run_op(1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule